// File: doc/BRIEF.md
# Stamped Memory Operation Serializer

This block is a reference model in hardware for checking a shared memory. Each memory operation is registered on a create port. The operation carries the requesting location, a kind (read, write or atomic), an address and a data word. The block returns a stamp for the operation. A stamp is later placed into a single global order through the commit port. When the commit is made, the block evaluates the operation against a small backing memory. The value the operation observed can then be fetched through the eval port.

Before a commit is accepted, the block checks the ordering rules. All operations that must precede the stamp have to be committed already. A commit that breaks this rule is refused and flagged. The sequence of accepted commits is therefore a legal serialization of the recorded operations. Committed entries stay in the table until a release returns them to the pool.

Top module: `smo_serializer`

## Requirements
- R1: A create is accepted when `create_valid_i` and `create_ready_o` are both high. The stamp given is the lowest-numbered free table entry. `create_ready_o` is low only while all table entries are occupied.
- R2: Kind encoding is 0 = read, 1 = write, 2 = atomic (3 acts as a read). Operation P precedes operation Q in two cases: they share a location and P was created earlier, or both are atomics to the same address and P was created earlier.
- R3: A commit of a live, uncommitted stamp is refused while any preceding operation is still uncommitted. The refusal raises `order_err_o` for one cycle in the next cycle and leaves all state unchanged.
- R4: A committed read observes the data of the most recently committed write or atomic to its address (0 after reset).
- R5: Committing a write stores its data at its address. Its eval returns its own data.
- R6: Committing an atomic is one read-modify-write. Its eval returns the old memory value, and the memory takes the new data in the same cycle.
- R7: A commit of a stamp that is already committed, or not allocated, raises `dup_err_o` for one cycle in the next cycle and has no other effect.
- R8: An eval of a stamp that is uncommitted or not allocated raises `eval_err_o` for one cycle in the next cycle and gives no response.
- R9: A release of a committed stamp frees its entry for reuse. A release of an uncommitted stamp is ignored.
- R10: An eval of a committed stamp answers in the next cycle with `eval_rsp_valid_o` and the observed value. After reset the table is empty, `create_ready_o` is high and no flag or response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| create_valid_i | input | 1 | Create request |
| create_ready_o | output | 1 | A table entry is free |
| create_loc_i | input | LOC_W | Requesting location |
| create_kind_i | input | 2 | Operation kind |
| create_addr_i | input | ADDR_W | Operation address |
| create_data_i | input | DATA_W | Write or atomic data |
| create_stamp_o | output | IDX_W | Stamp given to the request |
| commit_valid_i | input | 1 | Commit request |
| commit_ready_o | output | 1 | Commit accepted (always high) |
| commit_stamp_i | input | IDX_W | Stamp to commit |
| eval_valid_i | input | 1 | Eval request |
| eval_ready_o | output | 1 | Eval accepted (always high) |
| eval_stamp_i | input | IDX_W | Stamp to evaluate |
| eval_rsp_valid_o | output | 1 | Eval response valid |
| eval_rsp_data_o | output | DATA_W | Value observed by the operation |
| release_valid_i | input | 1 | Release request |
| release_ready_o | output | 1 | Release accepted (always high) |
| release_stamp_i | input | IDX_W | Stamp to free |
| order_err_o | output | 1 | Commit refused on ordering |
| dup_err_o | output | 1 | Commit of committed or free stamp |
| eval_err_o | output | 1 | Eval of uncommitted or free stamp |

## Verification
Several properties are checked on every cycle:
- A committed entry never has an outstanding predecessor.
- Every committed entry is also allocated.
- Each error flag follows its offending request.
- A handshaked create marks its entry live.
- A response appears only after an eval request.

The bench scenarios are needed for the value semantics. They show that reads see the latest committed write, that atomics return the old value and store the new one, and that commit order rather than creation order decides what a read sees. They also cover ordering through shared atomics, entry reuse after release, and the table-full stall.

// File: rtl/smo_pkg.sv
package smo_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_RSVD   = 2'd3
  } op_kind_e;
endpackage

// File: rtl/smo_alloc.sv
module smo_alloc #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] used_i,
  output logic             free_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!used_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign free_o = ~&used_i;
endmodule

// File: rtl/smo_dep.sv
module smo_dep #(
  parameter int N_ENT  = 16,
  parameter int LOC_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic [N_ENT-1:0]             pend_i,
  input  logic [N_ENT-1:0][LOC_W-1:0]  loc_i,
  input  logic [N_ENT-1:0]             atom_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0] addr_i,
  input  logic [LOC_W-1:0]             new_loc_i,
  input  logic                         new_atom_i,
  input  logic [ADDR_W-1:0]            new_addr_i,
  output logic [N_ENT-1:0]             dep_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic same_loc, atom_pair;
    assign same_loc  = loc_i[g] == new_loc_i;
    assign atom_pair = atom_i[g] & new_atom_i & (addr_i[g] == new_addr_i);
    assign dep_o[g]  = pend_i[g] & (same_loc | atom_pair);
  end
endmodule

// File: rtl/smo_mem.sv
module smo_mem #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign rd_data_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wr_data_i;
  end
endmodule

// File: rtl/smo_serializer.sv
module smo_serializer
  import smo_pkg::*;
#(
  parameter int N_STAMPS = 16,
  parameter int LOC_W    = 2,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(N_STAMPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              create_valid_i,
  output logic              create_ready_o,
  input  logic [LOC_W-1:0]  create_loc_i,
  input  logic [1:0]        create_kind_i,
  input  logic [ADDR_W-1:0] create_addr_i,
  input  logic [DATA_W-1:0] create_data_i,
  output logic [IDX_W-1:0]  create_stamp_o,
  input  logic              commit_valid_i,
  output logic              commit_ready_o,
  input  logic [IDX_W-1:0]  commit_stamp_i,
  input  logic              eval_valid_i,
  output logic              eval_ready_o,
  input  logic [IDX_W-1:0]  eval_stamp_i,
  output logic              eval_rsp_valid_o,
  output logic [DATA_W-1:0] eval_rsp_data_o,
  input  logic              release_valid_i,
  output logic              release_ready_o,
  input  logic [IDX_W-1:0]  release_stamp_i,
  output logic              order_err_o,
  output logic              dup_err_o,
  output logic              eval_err_o
);
  logic [N_STAMPS-1:0]               valid_q, committed_q;
  logic [N_STAMPS-1:0][N_STAMPS-1:0] dep_q;
  logic [N_STAMPS-1:0][LOC_W-1:0]    loc_q;
  logic [N_STAMPS-1:0][1:0]          kind_q;
  logic [N_STAMPS-1:0][ADDR_W-1:0]   addr_q;
  logic [N_STAMPS-1:0][DATA_W-1:0]   data_q, result_q;
  logic [N_STAMPS-1:0]               atom_vec, pend_vec, new_dep;

  logic create_fire, c_open, c_ok, c_order, c_state, e_ok, r_ok, mem_we;
  logic [DATA_W-1:0] mem_rd, c_result;
  op_kind_e c_kind;

  assign commit_ready_o  = 1'b1;
  assign eval_ready_o    = 1'b1;
  assign release_ready_o = 1'b1;

  smo_alloc #(.N_ENT(N_STAMPS)) u_alloc (
    .used_i (valid_q),
    .free_o (create_ready_o),
    .idx_o  (create_stamp_o)
  );

  for (genvar g = 0; g < N_STAMPS; g++) begin : g_vec
    assign atom_vec[g] = kind_q[g] == OP_ATOMIC;
    // an entry committing this cycle no longer orders the new one
    assign pend_vec[g] = valid_q[g] & ~committed_q[g] &
                         ~(c_ok && commit_stamp_i == IDX_W'(g));
  end

  smo_dep #(.N_ENT(N_STAMPS), .LOC_W(LOC_W), .ADDR_W(ADDR_W)) u_dep (
    .pend_i     (pend_vec),
    .loc_i      (loc_q),
    .atom_i     (atom_vec),
    .addr_i     (addr_q),
    .new_loc_i  (create_loc_i),
    .new_atom_i (create_kind_i == OP_ATOMIC),
    .new_addr_i (create_addr_i),
    .dep_o      (new_dep)
  );

  assign create_fire = create_valid_i & create_ready_o;

  assign c_kind   = op_kind_e'(kind_q[commit_stamp_i]);
  assign c_open   = valid_q[commit_stamp_i] & ~committed_q[commit_stamp_i];
  assign c_state  = commit_valid_i & ~c_open;
  assign c_order  = commit_valid_i & c_open & (|dep_q[commit_stamp_i]);
  assign c_ok     = commit_valid_i & c_open & ~(|dep_q[commit_stamp_i]);
  assign mem_we   = c_ok & (c_kind == OP_WRITE || c_kind == OP_ATOMIC);
  assign c_result = (c_kind == OP_WRITE) ? data_q[commit_stamp_i] : mem_rd;

  assign e_ok = eval_valid_i & valid_q[eval_stamp_i] & committed_q[eval_stamp_i];
  assign r_ok = release_valid_i & valid_q[release_stamp_i] & committed_q[release_stamp_i];

  smo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_q[commit_stamp_i]),
    .rd_data_o (mem_rd),
    .we_i      (mem_we),
    .wr_data_i (data_q[commit_stamp_i])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      committed_q <= '0;
      dep_q       <= '0;
      loc_q       <= '0;
      kind_q      <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      result_q    <= '0;
    end else begin
      if (c_ok) begin
        committed_q[commit_stamp_i] <= 1'b1;
        result_q[commit_stamp_i]    <= c_result;
        for (int i = 0; i < N_STAMPS; i++) dep_q[i][commit_stamp_i] <= 1'b0;
      end
      if (r_ok) begin
        valid_q[release_stamp_i]     <= 1'b0;
        committed_q[release_stamp_i] <= 1'b0;
      end
      if (create_fire) begin
        valid_q[create_stamp_o]     <= 1'b1;
        committed_q[create_stamp_o] <= 1'b0;
        dep_q[create_stamp_o]       <= new_dep;
        loc_q[create_stamp_o]       <= create_loc_i;
        kind_q[create_stamp_o]      <= create_kind_i;
        addr_q[create_stamp_o]      <= create_addr_i;
        data_q[create_stamp_o]      <= create_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_err_o      <= 1'b0;
      dup_err_o        <= 1'b0;
      eval_err_o       <= 1'b0;
      eval_rsp_valid_o <= 1'b0;
      eval_rsp_data_o  <= '0;
    end else begin
      order_err_o      <= c_order;
      dup_err_o        <= c_state;
      eval_err_o       <= eval_valid_i & ~e_ok;
      eval_rsp_valid_o <= e_ok;
      if (e_ok) eval_rsp_data_o <= result_q[eval_stamp_i];
    end
  end
endmodule

// File: rtl/smo_serializer_chk.sv
module smo_serializer_chk #(
  parameter int N_STAMPS = 16,
  localparam int IDX_W   = $clog2(N_STAMPS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         create_valid_i,
  input logic                         create_ready_o,
  input logic [IDX_W-1:0]             create_stamp_o,
  input logic                         commit_valid_i,
  input logic [IDX_W-1:0]             commit_stamp_i,
  input logic                         eval_valid_i,
  input logic [IDX_W-1:0]             eval_stamp_i,
  input logic                         eval_rsp_valid_o,
  input logic                         order_err_o,
  input logic                         dup_err_o,
  input logic                         eval_err_o,
  input logic [N_STAMPS-1:0]          valid_q,
  input logic [N_STAMPS-1:0]          committed_q,
  input logic [N_STAMPS-1:0][N_STAMPS-1:0] dep_q
);
  // R1
  create_marks_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    create_valid_i && create_ready_o |=> valid_q[$past(create_stamp_o)]);

  // R3
  order_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_i && valid_q[commit_stamp_i] && !committed_q[commit_stamp_i]
      && dep_q[commit_stamp_i] != '0 |=> order_err_o);

  for (genvar g = 0; g < N_STAMPS; g++) begin : g_inv
    // R3
    committed_no_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      committed_q[g] |-> dep_q[g] == '0);
  end

  // R7
  dup_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_i && committed_q[commit_stamp_i] |=> dup_err_o && !order_err_o);

  // R8
  eval_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_valid_i && !committed_q[eval_stamp_i] |=> eval_err_o && !eval_rsp_valid_o);

  // R9
  committed_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_q & ~valid_q) == '0);

  // R10
  rsp_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_rsp_valid_o |-> $past(eval_valid_i));
endmodule

bind smo_serializer smo_serializer_chk #(.N_STAMPS(N_STAMPS)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .create_valid_i   (create_valid_i),
  .create_ready_o   (create_ready_o),
  .create_stamp_o   (create_stamp_o),
  .commit_valid_i   (commit_valid_i),
  .commit_stamp_i   (commit_stamp_i),
  .eval_valid_i     (eval_valid_i),
  .eval_stamp_i     (eval_stamp_i),
  .eval_rsp_valid_o (eval_rsp_valid_o),
  .order_err_o      (order_err_o),
  .dup_err_o        (dup_err_o),
  .eval_err_o       (eval_err_o),
  .valid_q          (valid_q),
  .committed_q      (committed_q),
  .dep_q            (dep_q)
);

// File: tb/smo_serializer_tb.sv
module smo_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16, LOC_W = 2, ADDR_W = 3, DATA_W = 8, IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic create_valid, create_ready, commit_valid, commit_ready;
  logic eval_valid, eval_ready, release_valid, release_ready;
  logic [LOC_W-1:0] create_loc;
  logic [1:0] create_kind;
  logic [ADDR_W-1:0] create_addr;
  logic [DATA_W-1:0] create_data, rsp_data;
  logic [IDX_W-1:0] create_stamp, commit_stamp, eval_stamp, release_stamp;
  logic rsp_valid, order_err, dup_err, eval_err;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  smo_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .create_valid_i(create_valid), .create_ready_o(create_ready),
    .create_loc_i(create_loc), .create_kind_i(create_kind),
    .create_addr_i(create_addr), .create_data_i(create_data),
    .create_stamp_o(create_stamp),
    .commit_valid_i(commit_valid), .commit_ready_o(commit_ready),
    .commit_stamp_i(commit_stamp),
    .eval_valid_i(eval_valid), .eval_ready_o(eval_ready),
    .eval_stamp_i(eval_stamp),
    .eval_rsp_valid_o(rsp_valid), .eval_rsp_data_o(rsp_data),
    .release_valid_i(release_valid), .release_ready_o(release_ready),
    .release_stamp_i(release_stamp),
    .order_err_o(order_err), .dup_err_o(dup_err), .eval_err_o(eval_err)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pop expected eval results as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R8", "unexpected eval response", rsp_data, 0);
      else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(rsp_data == e, r, "eval data", rsp_data, e);
      end
    end
  end

  task automatic do_create(int loc, int kind, int addr, int data, int exp_stamp);
    @(negedge clk);
    create_valid = 1; create_loc = LOC_W'(loc); create_kind = 2'(kind);
    create_addr = ADDR_W'(addr); create_data = DATA_W'(data);
    #1;
    check(create_ready == 1'b1, "R1", "create ready", create_ready, 1);
    check(create_stamp == IDX_W'(exp_stamp), "R1", "stamp lowest free", create_stamp, exp_stamp);
    @(negedge clk);
    create_valid = 0;
  endtask

  task automatic do_commit(int s, bit exp_order, bit exp_dup, string req);
    @(negedge clk);
    commit_valid = 1; commit_stamp = IDX_W'(s);
    @(negedge clk);
    commit_valid = 0;
    check(order_err == exp_order, req, "order flag", order_err, exp_order);
    check(dup_err == exp_dup, req, "dup flag", dup_err, exp_dup);
  endtask

  task automatic do_eval(int s, bit exp_err, int exp_val, string req);
    @(negedge clk);
    eval_valid = 1; eval_stamp = IDX_W'(s);
    if (!exp_err) begin exp_q.push_back(DATA_W'(exp_val)); req_q.push_back(req); end
    @(negedge clk);
    eval_valid = 0;
    check(eval_err == exp_err, req, "eval error flag", eval_err, exp_err);
  endtask

  task automatic do_release(int s);
    @(negedge clk);
    release_valid = 1; release_stamp = IDX_W'(s);
    @(negedge clk);
    release_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "R10", "watchdog expired", 0, 1);
    finish_test();
  end

  initial begin
    create_valid = 0; commit_valid = 0; eval_valid = 0; release_valid = 0;
    create_loc = '0; create_kind = '0; create_addr = '0; create_data = '0;
    commit_stamp = '0; eval_stamp = '0; release_stamp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(create_ready == 1'b1, "R10", "ready after reset", create_ready, 1);
    check({order_err, dup_err, eval_err, rsp_valid} == 4'b0, "R10", "flags after reset",
          {order_err, dup_err, eval_err, rsp_valid}, 0);

    do_create(0, 1, 1, 'h11, 0);  // s0 loc0 write
    do_create(0, 0, 1, 'h00, 1);  // s1 loc0 read, after s0
    do_create(1, 0, 1, 'h00, 2);  // s2 loc1 read
    do_commit(1, 1, 0, "R3");     // s0 still open
    do_eval(1, 1, 0, "R8");       // refused commit left s1 open
    do_commit(2, 0, 0, "R3");
    do_eval(2, 0, 'h00, "R4");    // write not yet committed
    do_commit(0, 0, 0, "R5");
    do_commit(1, 0, 0, "R3");
    do_eval(1, 0, 'h11, "R4");
    do_eval(0, 0, 'h11, "R5");
    do_commit(0, 0, 1, "R7");
    do_eval(9, 1, 0, "R8");       // never allocated

    do_create(2, 2, 1, 'h22, 3);  // s3 atomic a1
    do_create(3, 2, 1, 'h33, 4);  // s4 atomic a1, after s3
    do_create(1, 2, 2, 'h44, 5);  // s5 atomic a2, unordered
    do_commit(4, 1, 0, "R2");
    do_commit(5, 0, 0, "R2");
    do_eval(5, 0, 'h00, "R6");
    do_commit(3, 0, 0, "R6");
    do_eval(3, 0, 'h11, "R6");
    do_commit(4, 0, 0, "R6");
    do_eval(4, 0, 'h22, "R6");
    do_create(0, 0, 1, 'h00, 6);  // s6 read a1
    do_commit(6, 0, 0, "R6");
    do_eval(6, 0, 'h33, "R6");

    do_create(0, 1, 3, 'h55, 7);  // s7 write a3
    do_release(7);                // uncommitted: ignored
    do_release(2);
    do_create(3, 0, 3, 'h00, 2);  // R9 reuse of entry 2
    do_commit(7, 0, 0, "R9");     // still held, so no dup flag
    do_eval(7, 0, 'h55, "R9");
    do_commit(2, 0, 0, "R4");
    do_eval(2, 0, 'h55, "R4");

    for (int i = 8; i < N; i++) do_create(0, 0, 0, 0, i);
    @(negedge clk);
    #1;
    check(create_ready == 1'b0, "R1", "ready low when full", create_ready, 0);
    do_release(6);
    do_create(2, 0, 0, 0, 6);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "missing eval responses", exp_q.size(), 0);
    finish_test();
  end
endmodule